// File: doc/BRIEF.md
# Second-Aligned Periodic Pulse Train Generator

This block produces up to three trains of single-cycle pulses at fixed intervals of time-of-day nanoseconds. A 32-bit interval value per channel sets the spacing of its train. Each clock the block adds the time step of one tick (in nanoseconds) to a per-channel accumulator. When the accumulated time reaches the interval, the channel emits a pulse and keeps the leftover time, so a spacing that is not a whole number of ticks does not drift.

The trains do not start on their own. Software first sets the arm bit while the timer is enabled. It then programs the alarm-1 comparator to one tick period before the next whole second. The alarm-1 match strobe starts all channels together, so the first pulse of every train lands on the second boundary. When the time of day is rewritten, the trains stop and wait for a fresh alarm match. A realign-disable control keeps them running through the time change instead.

Each pulse is also presented to the event unit at a fixed bit position. Channels 1 and 2 can be looped back to internal trigger lines.

The controller is a three-state machine:
- IDLE: nothing runs.
- ARMED: waiting for the alarm match.
- RUN: the trains are running.

Its transitions are:
- IDLE to ARMED when the timer is enabled and the arm bit is set.
- ARMED to RUN on the alarm-1 match.
- ARMED to IDLE when the arm bit is cleared.
- RUN to ARMED on a time change while realignment is allowed.
- Any state to IDLE when the timer enable drops.

Top module: `pulse_train_gen`

## Requirements
- R1: After reset the controller is IDLE, and all pulse, event and loopback outputs are 0.
- R2: An alarm-1 strobe has no effect unless the controller has been armed. Arming needs `timer_en` and `start_arm` both high.
- R3: While running, a channel with interval I emits a one-cycle pulse on each clock where its accumulated time reaches I. The accumulator grows by `tick_step` per clock and carries the remainder past I. With the accumulator starting at I minus the step, pulse n (counted in clocks after the alarm cycle) occurs when floor((I-S+nS)/I) increases.
- R4: The first pulse of every enabled channel appears in the clock that follows the clock in which the alarm strobe is accepted.
- R5: A channel whose interval is 0 never pulses.
- R6: `evt_bits` carries channel 1 on bit 7, channel 2 on bit 6 and channel 3 on bit 5. All other bits are 0.
- R7: `lb_pulse[k]` equals the pulse of channel k+1 when `lb_en[k]` is 1, and is 0 otherwise. Only channels 1 and 2 have loopback.
- R8: With `realign_dis` high, a `time_set` strobe leaves the trains running with unchanged phase.
- R9: With `realign_dis` low, a `time_set` strobe during RUN suppresses pulses from that clock on and returns to ARMED. The next alarm strobe restarts all trains as in R4.
- R10: Dropping `timer_en` forces IDLE and clears all pulses at the next clock. Alarms are then ignored.
- R11: Clearing `start_arm` while ARMED returns to IDLE, and a later alarm strobe starts nothing. Clearing it during RUN has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_en | input | 1 | Timer enable; low stops and disarms everything |
| start_arm | input | 1 | Arm request for the pulse trains |
| realign_dis | input | 1 | Keep trains running across time changes |
| lb_en | input | 2 | Loopback enables for channels 1 and 2 |
| tick_step | input | STEP_W (10) | Nanoseconds added per clock |
| alarm1_hit | input | 1 | One-cycle alarm-1 match strobe |
| time_set | input | 1 | One-cycle strobe: time of day was rewritten |
| interval | input | NCH x IW (3x32) | Per-channel interval in ns; 0 disables |
| pulse_out | output | NCH (3) | Pulse train outputs |
| evt_bits | output | 8 | Event-set vector toward the event unit |
| lb_pulse | output | 2 | Internal loopback triggers |

## Verification
The bench targets the following corner cases:
- A 20 ns interval against an 8 ns step. A design that dropped the remainder would space those pulses evenly at three ticks instead of 3/2/3.
- The exact cycle of the first pulse. An extra register on the alarm path would shift every train off the second boundary.
- Time changes under both realign settings. A design that ignored the realign control would either freeze a train that should continue or keep running out of phase.
- A zero interval, which must stay silent.
- Alarms that arrive while disabled or disarmed, which must not start a stray train.

// File: rtl/pulse_train_pkg.sv
package pulse_train_pkg;

    typedef enum logic [1:0] {
        PT_IDLE  = 2'd0,
        PT_ARMED = 2'd1,
        PT_RUN   = 2'd2
    } pt_state_e;

    // event-unit bit of channel 1; later channels occupy the bits below
    localparam int unsigned EVT_TOP_BIT = 7;
    localparam int unsigned EVT_W       = 8;
    localparam int unsigned LB_CH       = 2;

endpackage

// File: rtl/pulse_train_ctrl.sv
module pulse_train_ctrl
    import pulse_train_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      timer_en,
    input  logic      start_arm,
    input  logic      realign_dis,
    input  logic      alarm1_hit,
    input  logic      time_set,
    output logic      run,
    output logic      load,
    output pt_state_e state
);

    pt_state_e state_q;
    pt_state_e state_d;
    logic      jump_stop;

    assign jump_stop = time_set && !realign_dis;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PT_IDLE: begin
                if (timer_en && start_arm) begin
                    state_d = PT_ARMED;
                end
            end
            PT_ARMED: begin
                if (!timer_en || !start_arm) begin
                    state_d = PT_IDLE;
                end else if (alarm1_hit) begin
                    state_d = PT_RUN;
                end
            end
            PT_RUN: begin
                if (!timer_en) begin
                    state_d = PT_IDLE;
                end else if (jump_stop) begin
                    state_d = PT_ARMED;
                end
            end
            default: state_d = PT_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        run   = 1'b0;
        load  = 1'b0;
        unique case (state_q)
            PT_IDLE:  ;
            PT_ARMED: load = timer_en && start_arm && alarm1_hit;
            PT_RUN:   run  = timer_en && !jump_stop;
            default:  ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/pulse_train_chan.sv
module pulse_train_chan #(
    parameter int unsigned IW     = 32,
    parameter int unsigned STEP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              load,
    input  logic [IW-1:0]     interval,
    input  logic [STEP_W-1:0] tick_step,
    output logic              pulse
);

    localparam int unsigned AW = IW + 1;

    logic [AW-1:0] acc_q;
    logic [AW-1:0] step_x;
    logic [AW-1:0] ivl_x;
    logic [AW-1:0] acc_sum;
    logic [AW-1:0] residue;
    logic          reached;

    assign step_x  = AW'(tick_step);
    assign ivl_x   = AW'(interval);
    assign acc_sum = acc_q + step_x;
    assign reached = (acc_sum >= ivl_x);
    assign residue = acc_sum - ivl_x;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            pulse <= 1'b0;
        end else if (load) begin
            // preload so the first clock of the run lands on the interval
            acc_q <= (ivl_x > step_x) ? (ivl_x - step_x) : '0;
            pulse <= 1'b0;
        end else if (run && (interval != '0)) begin
            if (reached) begin
                pulse <= 1'b1;
                acc_q <= (residue >= ivl_x) ? '0 : residue;
            end else begin
                pulse <= 1'b0;
                acc_q <= acc_sum;
            end
        end else begin
            acc_q <= '0;
            pulse <= 1'b0;
        end
    end

endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen
    import pulse_train_pkg::*;
#(
    parameter int unsigned NCH    = 3,
    parameter int unsigned IW     = 32,
    parameter int unsigned STEP_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    timer_en,
    input  logic                    start_arm,
    input  logic                    realign_dis,
    input  logic [LB_CH-1:0]        lb_en,
    input  logic [STEP_W-1:0]       tick_step,
    input  logic                    alarm1_hit,
    input  logic                    time_set,
    input  logic [NCH-1:0][IW-1:0]  interval,
    output logic [NCH-1:0]          pulse_out,
    output logic [EVT_W-1:0]        evt_bits,
    output logic [LB_CH-1:0]        lb_pulse
);

    logic      run;
    logic      load;
    pt_state_e ctl_state;

    pulse_train_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .timer_en    (timer_en),
        .start_arm   (start_arm),
        .realign_dis (realign_dis),
        .alarm1_hit  (alarm1_hit),
        .time_set    (time_set),
        .run         (run),
        .load        (load),
        .state       (ctl_state)
    );

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_chan
            pulse_train_chan #(
                .IW     (IW),
                .STEP_W (STEP_W)
            ) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .run       (run),
                .load      (load),
                .interval  (interval[k]),
                .tick_step (tick_step),
                .pulse     (pulse_out[k])
            );
        end

        for (genvar b = 0; b < EVT_W; b++) begin : g_evt
            if ((b <= EVT_TOP_BIT) && (EVT_TOP_BIT - b < NCH)) begin : g_map
                assign evt_bits[b] = pulse_out[EVT_TOP_BIT - b];
            end else begin : g_zero
                assign evt_bits[b] = 1'b0;
            end
        end

        for (genvar m = 0; m < LB_CH; m++) begin : g_lb
            if (m < NCH) begin : g_on
                assign lb_pulse[m] = pulse_out[m] & lb_en[m];
            end else begin : g_off
                assign lb_pulse[m] = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/pulse_train_gen_chk.sv
module pulse_train_gen_chk
    import pulse_train_pkg::*;
#(
    parameter int unsigned NCH = 3,
    parameter int unsigned IW  = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   timer_en,
    input logic                   start_arm,
    input logic                   realign_dis,
    input logic                   alarm1_hit,
    input logic                   time_set,
    input logic [NCH-1:0][IW-1:0] interval,
    input logic [NCH-1:0]         pulse_out,
    input pt_state_e              st
);

    // R4: an accepted alarm moves the controller into RUN
    assert_alarm_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PT_ARMED && timer_en && start_arm && alarm1_hit) |=> (st == PT_RUN));

    // R8: time change with realignment disabled keeps running
    assert_keep_running_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PT_RUN && timer_en && time_set && realign_dis) |=> (st == PT_RUN));

    // R9: time change with realignment allowed re-arms and silences
    assert_realign_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PT_RUN && timer_en && time_set && !realign_dis)
        |=> (st == PT_ARMED && pulse_out == '0));

    // R10: timer disable stops and disarms
    assert_disable_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !timer_en |=> (st == PT_IDLE && pulse_out == '0));

    // R11: dropping the arm bit while waiting returns to IDLE
    assert_disarm_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PT_ARMED && !start_arm) |=> (st == PT_IDLE));

    // R2: no pulses unless running
    assert_quiet_unless_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st != PT_RUN) |=> (pulse_out == '0));

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_zero
            // R5: zero interval never pulses
            assert_zero_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (interval[k] == '0) |=> !pulse_out[k]);
        end
    endgenerate

endmodule

bind pulse_train_gen pulse_train_gen_chk #(
    .NCH (NCH),
    .IW  (IW)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .timer_en    (timer_en),
    .start_arm   (start_arm),
    .realign_dis (realign_dis),
    .alarm1_hit  (alarm1_hit),
    .time_set    (time_set),
    .interval    (interval),
    .pulse_out   (pulse_out),
    .st          (ctl_state)
);

// File: tb/pulse_train_gen_tb_top.sv
module pulse_train_gen_tb_top;

    localparam int S = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            timer_en = 1'b0;
    logic            start_arm = 1'b0;
    logic            realign_dis = 1'b0;
    logic [1:0]      lb_en = 2'b00;
    logic [9:0]      tick_step = 10'(S);
    logic            alarm1_hit = 1'b0;
    logic            time_set = 1'b0;
    logic [2:0][31:0] iv_bus;
    logic [2:0]      pulse_out;
    logic [7:0]      evt_bits;
    logic [1:0]      lb_pulse;

    int iv [3] = '{0, 0, 0};
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    assign iv_bus = {iv[2][31:0], iv[1][31:0], iv[0][31:0]};

    always #10 clk = ~clk;

    pulse_train_gen dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .timer_en    (timer_en),
        .start_arm   (start_arm),
        .realign_dis (realign_dis),
        .lb_en       (lb_en),
        .tick_step   (tick_step),
        .alarm1_hit  (alarm1_hit),
        .time_set    (time_set),
        .interval    (iv_bus),
        .pulse_out   (pulse_out),
        .evt_bits    (evt_bits),
        .lb_pulse    (lb_pulse)
    );

    function automatic bit mdl(int i, int s, int n);
        if (i == 0 || n < 1) return 1'b0;
        return ((i - s + n * s) / i) != ((i - s + (n - 1) * s) / i);
    endfunction

    task automatic chk(input string rq, input int act, input int exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // advance one clock and compare all outputs with the model at run index n
    task automatic step_chk(input string rq, input bit act, input int n);
        logic [2:0] ep;
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 3; k++) ep[k] = act && mdl(iv[k], S, n);
        chk(rq, int'(pulse_out[1:0]), int'(ep[1:0]), $sformatf("ch1/ch2 pulse n=%0d", n));
        if (iv[2] == 0) chk("R5", int'(pulse_out[2]), 0, "zero-interval channel");
        else            chk(rq, int'(pulse_out[2]), int'(ep[2]), $sformatf("ch3 pulse n=%0d", n));
        chk("R6", int'(evt_bits), int'({ep[0], ep[1], ep[2], 5'b0}), "event vector");
        chk("R7", int'(lb_pulse), int'(ep[1:0] & lb_en), "loopback");
    endtask

    task automatic fire_alarm();
        @(negedge clk) alarm1_hit = 1'b1;
        @(posedge clk);
        @(negedge clk) alarm1_hit = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", int'(pulse_out), 0, "pulses in reset");
        chk("R1", int'(evt_bits), 0, "events in reset");
        chk("R1", int'(lb_pulse), 0, "loopback in reset");
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_no_arm();
        iv[0] = 40; iv[1] = 20; iv[2] = 0;
        timer_en = 1'b1;
        fire_alarm();
        for (int n = 1; n <= 8; n++) step_chk("R2", 1'b0, n);
    endtask

    task automatic t_run();
        lb_en = 2'b01;
        start_arm = 1'b1;
        @(negedge clk);
        fire_alarm();
        step_chk("R3", 1'b1, 1);
        chk("R4", int'(pulse_out[1:0]), 3, "first pulse on boundary");
        for (int n = 2; n <= 24; n++) step_chk("R3", 1'b1, n);
    endtask

    task automatic t_realign_off();
        lb_en = 2'b10;
        realign_dis = 1'b1;
        time_set = 1'b1;
        step_chk("R8", 1'b1, 25);
        time_set = 1'b0;
        for (int n = 26; n <= 34; n++) step_chk("R8", 1'b1, n);
    endtask

    task automatic t_realign_on();
        realign_dis = 1'b0;
        time_set = 1'b1;
        step_chk("R9", 1'b0, 35);
        time_set = 1'b0;
        for (int n = 36; n <= 44; n++) step_chk("R9", 1'b0, n);
        iv[2] = 16;
        fire_alarm();
        for (int n = 1; n <= 12; n++) step_chk("R9", 1'b1, n);
    endtask

    task automatic t_disable();
        timer_en = 1'b0;
        step_chk("R10", 1'b0, 13);
        fire_alarm();
        for (int n = 1; n <= 6; n++) step_chk("R10", 1'b0, n);
    endtask

    task automatic t_disarm();
        start_arm = 1'b0;
        timer_en = 1'b1;
        @(negedge clk);
        fire_alarm();
        for (int n = 1; n <= 5; n++) step_chk("R11", 1'b0, n);
        start_arm = 1'b1;
        @(negedge clk);
        start_arm = 1'b0;
        @(negedge clk);
        fire_alarm();
        for (int n = 1; n <= 6; n++) step_chk("R11", 1'b0, n);
    endtask

    initial begin
        t_reset();
        t_no_arm();
        t_run();
        t_realign_off();
        t_realign_on();
        t_disable();
        t_disarm();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule